// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four pulse-width-modulated outputs from a single core clock. Every channel divides the clock twice. A 16-bit prescaler first produces slow ticks, and a 16-bit period counter then counts those ticks. A 16-bit high-time compare decides how many ticks of each period the output spends high. The channels share nothing but the clock, the reset and the register port, so each one can run at its own rate and duty.

Software writes settings through a word-addressed register port. Divider, prescaler and high-time values are first kept in a staging bank and have no effect on the waveform. They move into the active bank only when software raises the channel's update flag. If the channel is running, the move happens on the next period boundary, so a period is never cut short or stretched. If the channel is stopped, the move happens at once. The update flag reads back as 1 while a move is waiting.

Top module: `quad_pwm`

## Requirements
- R1: After reset every output is low and all eight register words read 0.
- R2: Word index 2*c+r addresses register r of channel c. Word 0 of a channel holds the high time in bits [31:16] and the period divider in bits [15:0]. Word 1 holds the run flag in bit 31, the update flag in bit 30 and the prescaler in bits [15:0]. Bits [29:16] of word 1 read 0, and reads return the staged values.
- R3: A running channel repeats every (prescaler+1)*(divider+1) clock cycles.
- R4: Each period begins with the output high for high_time*(prescaler+1) cycles and ends with it low for the rest.
- R5: With a high time of 0 the output never goes high. With a high time of at least divider+1 the output never goes low.
- R6: While the run flag is 0 the output is low. A write that sets the run flag starts a fresh period with both counters at zero, beginning with the clock edge that captures the write.
- R7: Writing word 0 without an update does not alter the running waveform, and the update flag stays 0.
- R8: An update requested while running reads back 1 until the next period boundary. The new settings apply from that boundary, and the flag then reads 0.
- R9: An update written while the channel is stopped takes effect on the same edge, and the update flag reads 0 right away.
- R10: Writing or running one channel does not change the register contents or the output of any other channel.
- R11: A write of run=0 together with update=1 drives the output low from the capturing edge. The pending update completes one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock for all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the register port |
| cfg_addr | input | 3 | Word index, 2*channel + register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the word at cfg_addr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A corrupted prescaler or period counter shows up as a high or low run of the wrong length on the channel's pin, within one period of the fault. The bench therefore compares every sampled pin value against a closed-form function of the cycles elapsed since the enabling or transferring edge. A settings transfer at the wrong moment changes the waveform at a cycle that differs from the computed boundary. A stuck update flag is caught when the flag is read back before and after that boundary. Wrong address decode appears at once as a changed readback or a toggling pin on a channel that was never written.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned RUN_BIT = 31;
  localparam int unsigned UPD_BIT = 30;
  localparam int unsigned HI_LSB  = 16;

  typedef struct packed {
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] div;
    logic [FIELD_W-1:0] pre;
  } qpwm_set_t;
endpackage

// File: rtl/qpwm_chan_cfg.sv
module qpwm_chan_cfg
  import qpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word0,
  input  logic              wr_word1,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wrap_i,
  output logic              run_o,
  output qpwm_set_t         act_o,
  output logic [WORD_W-1:0] rd_word0,
  output logic [WORD_W-1:0] rd_word1
);
  localparam int unsigned PAD_W = WORD_W - 2 - FIELD_W;

  qpwm_set_t stage_q, stage_d, act_q, act_d;
  logic      run_q, run_d, pend_q, pend_d;
  logic      upd_req, drain, load;
  logic      unused_wbits;

  assign unused_wbits = ^wdata[UPD_BIT-1:FIELD_W];

  always_comb begin
    stage_d = stage_q;
    run_d   = run_q;
    pend_d  = pend_q;
    if (wr_word0) begin
      stage_d.div = wdata[FIELD_W-1:0];
      stage_d.hi  = wdata[HI_LSB +: FIELD_W];
    end
    if (wr_word1) begin
      stage_d.pre = wdata[FIELD_W-1:0];
      run_d       = wdata[RUN_BIT];
    end
    upd_req = wr_word1 && wdata[UPD_BIT];
    drain   = pend_q && (!run_q || wrap_i);
    load    = (upd_req && !run_q) || drain;
    if (drain)             pend_d = 1'b0;
    if (upd_req && run_q)  pend_d = 1'b1;
    act_d = load ? stage_d : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
      run_q   <= run_d;
      pend_q  <= pend_d;
    end
  end

  assign run_o    = run_q;
  assign act_o    = act_q;
  assign rd_word0 = {stage_q.hi, stage_q.div};
  assign rd_word1 = {run_q, pend_q, {PAD_W{1'b0}}, stage_q.pre};

  // Active settings only change at a period boundary while running.
  assert_hold_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap_i) |=> $stable(act_q));

  // A pending transfer on a stopped channel completes on the next edge.
  assert_pend_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !run_q) |=> !pend_q);

  // An update requested while running stays visible until a boundary.
  assert_pend_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && run_q && !wrap_i && !(wr_word1 && !wdata[RUN_BIT])) |=> pend_q);
endmodule

// File: rtl/qpwm_chan_gen.sv
module qpwm_chan_gen
  import qpwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  qpwm_set_t act_i,
  output logic      wrap_o,
  output logic      pwm_o
);
  logic [FIELD_W-1:0] tick_q, tick_d, slot_q, slot_d;
  logic               tick_last, slot_last;

  always_comb begin
    tick_last = (tick_q == act_i.pre);
    slot_last = (slot_q == act_i.div);
    tick_d    = tick_q;
    slot_d    = slot_q;
    if (!run_i) begin
      tick_d = '0;
      slot_d = '0;
    end else if (tick_last) begin
      tick_d = '0;
      slot_d = slot_last ? '0 : slot_q + 1'b1;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
    end else begin
      tick_q <= tick_d;
      slot_q <= slot_d;
    end
  end

  assign wrap_o = run_i && tick_last && slot_last;
  assign pwm_o  = run_i && (slot_q < act_i.hi);

  // Counters never pass the active limits.
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q <= act_i.div) && (tick_q <= act_i.pre));

  // A stopped channel restarts from zero.
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (tick_q == '0) && (slot_q == '0));
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import qpwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned NUM_WORDS = 2 * NUM_CH,
  localparam int unsigned ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [NUM_CH-1:0] run;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qpwm_set_t act;
    logic      wrap;
    logic      hit0, hit1;

    assign hit0 = cfg_we && (cfg_addr == ADDR_W'(2*c));
    assign hit1 = cfg_we && (cfg_addr == ADDR_W'(2*c+1));

    qpwm_chan_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_word0 (hit0),
      .wr_word1 (hit1),
      .wdata    (cfg_wdata),
      .wrap_i   (wrap),
      .run_o    (run[c]),
      .act_o    (act),
      .rd_word0 (words[2*c]),
      .rd_word1 (words[2*c+1])
    );

    qpwm_chan_gen u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run[c]),
      .act_i  (act),
      .wrap_o (wrap),
      .pwm_o  (pwm_out[c])
    );

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |-> !pwm_out[c]);

    assert_zero_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act.hi == '0) |-> !pwm_out[c]);
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (cfg_addr == ADDR_W'(w)) cfg_rdata = words[w];
    end
  end
endmodule

// File: tb/quad_pwm_test.sv
module quad_pwm_test;
  localparam logic [31:0] RUN = 32'h8000_0000;
  localparam logic [31:0] UPD = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pwm_out;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  quad_pwm uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic wr(input int addr, input logic [31:0] data, output int edge_no);
    cfg_addr  = 3'(addr);
    cfg_wdata = data;
    cfg_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we  = 1'b0;
    edge_no = cyc;
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    cfg_addr = 3'(addr);
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic check_wave(input int ch, input int start, input int pre, input int dv,
                            input int hi, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int k = cyc - start;
      int slot = (k / (pre + 1)) % (dv + 1);
      bit e = (slot < hi);
      chk(pwm_out[ch] == e, tag, pwm_out[ch], e);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(pwm_out == 4'b0, "R1 outputs low", pwm_out, 0);
    for (int w = 0; w < 8; w++) rd(w, 32'h0, "R1 word reset");
  endtask

  task automatic t_regmap;
    int e;
    wr(4, 32'hABCD_1234, e);
    wr(5, 32'h3FFF_0055, e);
    rd(4, 32'hABCD_1234, "R2 word0 readback");
    rd(5, 32'h0000_0055, "R2 word1 pad bits");
    for (int w = 0; w < 4; w++) rd(w, 32'h0, "R10 other channel words");
    rd(6, 32'h0, "R10 channel3 word0");
    chk(pwm_out == 4'b0, "R6 stopped outputs low", pwm_out, 0);
  endtask

  task automatic t_basic;
    int e, d;
    wr(0, {16'd2, 16'd3}, e);
    wr(1, RUN | UPD | 32'd1, e);
    rd(1, 32'h8000_0001, "R9 update clear at once");
    check_wave(0, e, 1, 3, 2, 24, "R3 R4 R6 basic wave");
    wr(1, UPD | 32'd1, d);
    chk(pwm_out[0] == 1'b0, "R11 low on stop", pwm_out[0], 0);
    rd(1, 32'h4000_0001, "R11 pending after stop");
    @(negedge clk);
    rd(1, 32'h0000_0001, "R11 pending drained");
    check_wave(0, d, 0, 0, 0, 5, "R6 stays low");
  endtask

  task automatic t_extremes;
    int e;
    wr(2, {16'd0, 16'd2}, e);
    wr(3, RUN | UPD, e);
    check_wave(1, e, 0, 2, 0, 12, "R5 zero high time");
    wr(3, UPD, e);
    wr(2, {16'd5, 16'd2}, e);
    wr(3, RUN | UPD | 32'd2, e);
    check_wave(1, e, 2, 2, 5, 12, "R5 full high time");
    wr(3, UPD | 32'd2, e);
    @(negedge clk);
  endtask

  task automatic t_staged_and_update;
    int e, u, x, w;
    wr(6, {16'd2, 16'd4}, e);
    wr(7, RUN | UPD, e);
    check_wave(3, e, 0, 4, 2, 7, "R4 channel3 start");
    wr(6, {16'd1, 16'd1}, x);
    check_wave(3, e, 0, 4, 2, 15, "R7 staged ignored");
    rd(7, 32'h8000_0000, "R7 no pending");
    wr(7, RUN | UPD, u);
    w = e + 5 * ((u - e) / 5 + 1);
    rd(7, 32'hC000_0000, "R8 pending visible");
    check_wave(3, e, 0, 4, 2, w - u, "R8 old until boundary");
    rd(7, 32'h8000_0000, "R8 pending cleared");
    check_wave(3, w, 0, 1, 1, 10, "R8 new after boundary");
    // Second channel runs alongside.
    wr(4, {16'd3, 16'd5}, x);
    wr(5, RUN | UPD | 32'd2, e);
    check_wave(2, e, 2, 5, 3, 20, "R10 channel2 own wave");
    check_wave(3, w, 0, 1, 1, 10, "R10 channel3 undisturbed");
    chk(pwm_out[1:0] == 2'b0, "R10 idle channels low", pwm_out[1:0], 0);
    rd(0, {16'd2, 16'd3}, "R10 channel0 regs kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_basic;
    t_extremes;
    t_staged_and_update;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule